// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit

A purely combinational 32-bit integer adder/subtractor. It returns a sum or difference of two operands together with four condition flags: negative (N), zero (Z), carry (C) and signed overflow (V). A 2-bit opcode selects one of four operations. Two of them chain an incoming carry flag for multi-word arithmetic.

The carry flag uses the carry-means-no-borrow convention for subtraction. After a subtract, C is 1 when no borrow was needed. The subtract-with-carry operation takes away one extra unit when the incoming carry is 0. The unit has no state. A surrounding datapath registers the flags and feeds C back in for the next word.

Top module: `addsub_flags`

## Requirements
- R1: The opcode `op` selects the operation: 2'b00 add (A+B), 2'b01 add-with-carry, 2'b10 subtract (A-B), 2'b11 subtract-with-carry. The 32-bit result wraps modulo 2^32.
- R2: For add, C is 1 exactly when the unsigned result is less than A.
- R3: For add-with-carry with `c_in`=1, the result is A+B+1 and C is 1 exactly when the unsigned result is less than or equal to A. With `c_in`=0 it behaves as add.
- R4: For subtract, C is 1 exactly when A is unsigned greater than or equal to B.
- R5: For subtract-with-carry with `c_in`=0, the result is A-B-1 and C is 1 exactly when A is unsigned greater than B. With `c_in`=1 it behaves as subtract.
- R6: For both add operations, V is 1 exactly when A and B share a sign bit and the result's bit 31 differs from A's.
- R7: For both subtract operations, V is 1 exactly when the sign bits of A and B differ and the result's bit 31 differs from A's.
- R8: N equals bit 31 of the result, and Z is 1 exactly when the result is all zeros.
- R9: `c_in` has no effect on any output when `op` is 2'b00 or 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 2 | Operation select (see R1) |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| c_in | input | 1 | Current carry flag |
| res | output | 32 | Result |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| c_out | output | 1 | Carry / no-borrow flag |
| v_out | output | 1 | Signed overflow flag |

## Verification
The hardest cases are the carry-chained boundaries, where the extra unit from `c_in` decides the carry by itself.

- Add-with-carry with B all ones and `c_in`=1 returns exactly A, and C must still be 1.
- Subtract-with-carry with A equal to B and `c_in`=0 must borrow through to all ones with C cleared.

Random operands almost never hit these points. The stimulus therefore sweeps a grid of edge operands (zero, one, all ones, largest positive, most negative) across every opcode and both carry inputs before the random phase. The same grid also exercises every sign combination for the overflow rules and repeats each plain add and subtract with the carry input flipped.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         n_out,
  output logic         z_out,
  output logic         c_out,
  output logic         v_out
);
  localparam int MSB = W - 1;

  logic         is_sub;
  logic         use_cin;
  logic         cy0;
  logic [W-1:0] b_eff;
  logic [W:0]   sum_w;

  assign is_sub  = op[1];
  assign use_cin = op[0];
  // subtract: A + ~B + 1 ; chained ops substitute the incoming carry
  assign cy0     = use_cin ? c_in : is_sub;
  assign b_eff   = is_sub ? ~opb : opb;
  assign sum_w   = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, cy0};

  assign res   = sum_w[MSB:0];
  assign c_out = sum_w[W];
  assign n_out = sum_w[MSB];
  assign z_out = ~|sum_w[MSB:0];
  assign v_out = (opa[MSB] == b_eff[MSB]) && (sum_w[MSB] != opa[MSB]);

  always_comb begin
    if (op == 2'b00) AST_ADD_WRAP: assert (c_out == (res < opa)); // R2
    if (op == 2'b01 && c_in) AST_ADC_WRAP: assert (c_out == (res <= opa)); // R3
    if (op == 2'b10) AST_SUB_NOBORROW: assert (c_out == (opa >= opb)); // R4
    if (op == 2'b11 && !c_in) AST_SBC_NOBORROW: assert (c_out == (opa > opb)); // R5
    if (!is_sub && opa[MSB] != opb[MSB]) AST_ADD_NO_OVERFLOW: assert (!v_out); // R6
    if (is_sub && opa[MSB] == opb[MSB]) AST_SUB_NO_OVERFLOW: assert (!v_out); // R7
    AST_ZERO_NOT_NEG: assert (!(z_out && n_out)); // R8
  end
endmodule

// File: tb/addsub_flags_tb.sv
module addsub_flags_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic [1:0]  op;
  logic [31:0] opa, opb;
  logic        c_in;
  logic [31:0] res;
  logic        n_out, z_out, c_out, v_out;

  addsub_flags dut_i (.op(op), .opa(opa), .opb(opb), .c_in(c_in), .res(res),
                      .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out));

  typedef struct packed {
    logic [1:0]  op;
    logic        cin;
    logic [31:0] a, b, r;
    logic        n, z, c, v;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic item_t model(logic [1:0] o, logic [31:0] a, logic [31:0] b, logic ci);
    item_t t;
    t.op = o; t.a = a; t.b = b; t.cin = ci;
    case (o)
      2'b00: begin t.r = a + b; t.c = (t.r < a); end
      2'b01: if (ci) begin t.r = a + b + 32'd1; t.c = (t.r <= a); end
             else    begin t.r = a + b; t.c = (t.r < a); end
      2'b10: begin t.r = a - b; t.c = (a >= b); end
      default: if (!ci) begin t.r = a - b - 32'd1; t.c = (a > b); end
               else     begin t.r = a - b; t.c = (a >= b); end
    endcase
    if (o[1]) t.v = (a[31] != b[31]) && (t.r[31] != a[31]);
    else      t.v = (a[31] == b[31]) && (t.r[31] != a[31]);
    t.n = t.r[31];
    t.z = (t.r == 32'd0);
    return t;
  endfunction

  task automatic send(logic [1:0] o, logic [31:0] a, logic [31:0] b, logic ci);
    @(posedge clk); #1;
    op = o; opa = a; opb = b; c_in = ci;
    exp_q.push_back(model(o, a, b, ci));
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp, item_t t);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%0d cin=%0b a=%h b=%h actual=%h expected=%h",
               req, t.op, t.cin, t.a, t.b, act, exp);
    end
  endtask

  // monitor: compares away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t t;
        string rr, cr, vr;
        t = exp_q.pop_front();
        rr = (t.op == 2'b01) ? "R3" : (t.op == 2'b11) ? "R5" : "R1";
        cr = (t.op == 2'b00) ? "R2" : (t.op == 2'b01) ? "R3" : (t.op == 2'b10) ? "R4" : "R5";
        vr = t.op[1] ? "R7" : "R6";
        if (!t.op[0] && t.cin) begin rr = "R9"; cr = "R9"; vr = "R9"; end
        check(res == t.r, rr, res, t.r, t);
        check(c_out == t.c, cr, {31'b0, c_out}, {31'b0, t.c}, t);
        check(v_out == t.v, vr, {31'b0, v_out}, {31'b0, t.v}, t);
        check(n_out == t.n && z_out == t.z, "R8", {30'b0, n_out, z_out}, {30'b0, t.n, t.z}, t);
      end
    end
  end

  initial begin
    automatic logic [31:0] edges [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
    op = 2'b00; opa = 0; opb = 0; c_in = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // idle state: zero operands give zero result with Z set (R8)
    @(negedge clk);
    checks++;
    if (res !== 32'd0 || z_out !== 1'b1 || c_out !== 1'b0 || v_out !== 1'b0) begin
      fails++;
      $display("FAIL R8 idle actual=%h expected=%h", {res, z_out}, {32'd0, 1'b1});
    end
    // targeted chained-carry boundaries (R3, R5)
    send(2'b01, 32'h1234_5678, 32'hFFFF_FFFF, 1'b1);
    send(2'b11, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0);
    send(2'b11, 32'h0, 32'h0, 1'b0);
    // edge grid
    for (int o = 0; o < 4; o++)
      for (int ci = 0; ci < 2; ci++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            send(o[1:0], edges[i], edges[j], ci[0]);
    // random phase, with cin-flip pairs for R9
    for (int k = 0; k < 2000; k++) begin
      automatic logic [31:0] a = $urandom();
      automatic logic [31:0] b = $urandom();
      automatic logic [1:0] o = 2'($urandom_range(0, 3));
      send(o, a, b, 1'b0);
      send(o, a, b, 1'b1);
    end
    @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule